// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device side of a host mailbox for an embedded controller. A host reaches it over a byte-wide I/O bus through two ports. One is a data port. The other is shared: a write to it delivers a command byte, and a read from it returns a status byte. A sequencer takes each byte the host delivers and runs short command sequences against a 256-byte internal register space. The sequences are register read, register write, burst enable, burst disable and event query.

Pacing rests on two flags. The input-full flag is set by every host write and stays set until the sequencer has taken the byte. The output-full flag is set when a result byte is ready, and a host read of the data port clears it. A polling host waits for input-full to be clear before each write, and waits for output-full to be set before each read of the data port.

An event source pulses a strobe with an 8-bit event number. This raises the SCI-pending status bit. A query command returns the latched number while that bit is set. A separate SMI request input is mirrored into the status byte.

The sequencer has five states:
- IDLE waits for a command.
- RD_ADDR waits for the address byte of a read.
- RD_FETCH is a single busy cycle in which the fetched byte goes to the output register.
- WR_ADDR waits for the address byte of a write.
- WR_DATA waits for the data byte of a write.

Its transitions:
- Any command byte restarts decoding. The read command goes IDLE→RD_ADDR, the write command goes IDLE→WR_ADDR, and every other command returns to IDLE.
- An address byte goes RD_ADDR→RD_FETCH or WR_ADDR→WR_DATA.
- A data byte goes WR_DATA→IDLE and stores the byte.
- RD_FETCH always goes to IDLE on the next cycle.
- A data byte taken in IDLE stays in IDLE.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00 while the SMI request input is low.
- R2: A host write to either port sets input-full (status bit 1) after the write edge. Status bit 3 then reads 1 for a byte sent to the command port and 0 for one sent to the data port. When the sequencer is idle, input-full clears one clock later.
- R3: Command 0x80 followed by an address byte on the data port returns the byte stored at that address through the data port. Output-full (status bit 0) is still 0 one clock after the address write edge and reads 1 two clocks after it.
- R4: Command 0x81 followed by an address byte and then a data byte stores the data byte at that address.
- R5: Command 0x82 sets burst mode (status bit 4) and places the acknowledge byte 0x90 in the data port with output-full set.
- R6: Command 0x83 clears burst mode and does not set output-full.
- R7: An event strobe latches its 8-bit number and sets SCI-pending (status bit 5). Command 0x84 returns that number with output-full set, or 0x00 when SCI-pending is clear. Reading the query result clears SCI-pending.
- R8: A host read of the data port clears output-full.
- R9: An unknown command byte (0x99 is used) is dropped. A data byte written while idle is ignored apart from clearing input-full: output-full stays 0 and no register changes.
- R10: A command byte that arrives in the middle of a sequence abandons that sequence. A write interrupted after its address byte stores nothing.
- R11: The SMI request input appears in status bit 6 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one clock per access |
| host_wr | input | 1 | 1 for a write access, 0 for a read access |
| host_cmd_port | input | 1 | 1 selects the command/status port, 0 selects the data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte when the command port is selected, otherwise the output byte |
| evt_strb | input | 1 | Pulse that raises a pending event |
| evt_code | input | 8 | Event number captured with the strobe |
| smi_req | input | 1 | SMI request level, mirrored into status |

## Verification
Directed cases first cover the command codes one at a time. They include a read sequence whose output-full flag is sampled on each of the three clocks after the address write, which separates a correct fetch latency from one that is one clock early or late. Queries run both with and without a pending event, so a missing latch or a missing clear of SCI-pending shows up as a wrong byte or a stuck bit. An unknown command, a stray data byte and a write aborted by a new command check that nothing is stored where nothing should be. A seeded random run of register writes to random addresses, followed by read-backs, compares every returned byte against a bench model of the register space, which catches address or data mix-ups.

// File: rtl/ec_pkg.sv
package ec_pkg;
    localparam logic [7:0] CMD_RD_REG  = 8'h80;
    localparam logic [7:0] CMD_WR_REG  = 8'h81;
    localparam logic [7:0] CMD_BURST_E = 8'h82;
    localparam logic [7:0] CMD_BURST_D = 8'h83;
    localparam logic [7:0] CMD_QUERY   = 8'h84;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_RD_ADDR  = 3'd1,
        S_RD_FETCH = 3'd2,
        S_WR_ADDR  = 3'd3,
        S_WR_DATA  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/ec_regfile.sv
module ec_regfile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Registered read port: data appears one clock after re.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/ec_seq.sv
module ec_seq
    import ec_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter logic [DW-1:0] BURST_ACK = 8'h90
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ibf,
    input  logic          in_cmd,
    input  logic [DW-1:0] in_byte,
    input  logic [DW-1:0] rd_byte,
    input  logic          sci_pend,
    input  logic [DW-1:0] evt_num,
    output logic          consume,
    output logic          busy,
    output logic          obf_set,
    output logic [DW-1:0] out_byte,
    output logic          out_is_query,
    output logic          burst_on,
    output logic          burst_off,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    seq_state_e    state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    assign busy    = (state_q == S_RD_FETCH);
    assign consume = ibf && !busy;

    // Next-state and output process
    always_comb begin
        state_d      = state_q;
        addr_d       = addr_q;
        obf_set      = 1'b0;
        out_byte     = '0;
        out_is_query = 1'b0;
        burst_on     = 1'b0;
        burst_off    = 1'b0;
        mem_we       = 1'b0;
        mem_re       = 1'b0;
        mem_addr     = addr_q;
        mem_wdata    = in_byte;
        if (consume && in_cmd) begin
            unique case (in_byte)
                CMD_RD_REG:  state_d = S_RD_ADDR;
                CMD_WR_REG:  state_d = S_WR_ADDR;
                CMD_BURST_E: begin
                    state_d  = S_IDLE;
                    burst_on = 1'b1;
                    obf_set  = 1'b1;
                    out_byte = BURST_ACK;
                end
                CMD_BURST_D: begin
                    state_d   = S_IDLE;
                    burst_off = 1'b1;
                end
                CMD_QUERY: begin
                    state_d      = S_IDLE;
                    obf_set      = 1'b1;
                    out_is_query = 1'b1;
                    out_byte     = sci_pend ? evt_num : '0;
                end
                default: state_d = S_IDLE;
            endcase
        end else if (consume) begin
            unique case (state_q)
                S_RD_ADDR: begin
                    mem_re   = 1'b1;
                    mem_addr = in_byte[AW-1:0];
                    state_d  = S_RD_FETCH;
                end
                S_WR_ADDR: begin
                    addr_d  = in_byte[AW-1:0];
                    state_d = S_WR_DATA;
                end
                S_WR_DATA: begin
                    mem_we  = 1'b1;
                    state_d = S_IDLE;
                end
                default: state_d = S_IDLE;
            endcase
        end else if (busy) begin
            obf_set  = 1'b1;
            out_byte = rd_byte;
            state_d  = S_IDLE;
        end
    end
endmodule

// File: rtl/ec_status.sv
module ec_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd_data,
    input  logic          host_cmd_port,
    input  logic [DW-1:0] host_wdata,
    input  logic          consume,
    input  logic          obf_set,
    input  logic [DW-1:0] out_byte,
    input  logic          out_is_query,
    input  logic          burst_on,
    input  logic          burst_off,
    input  logic          evt_strb,
    input  logic [DW-1:0] evt_code,
    input  logic          smi_req,
    output logic          ibf,
    output logic          obf,
    output logic          in_cmd,
    output logic [DW-1:0] in_byte,
    output logic [DW-1:0] out_q,
    output logic          burst,
    output logic          sci,
    output logic [DW-1:0] evt_num,
    output logic [7:0]    status
);
    logic qry_q, smi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf     <= 1'b0;
            obf     <= 1'b0;
            in_cmd  <= 1'b0;
            in_byte <= '0;
            out_q   <= '0;
            qry_q   <= 1'b0;
            burst   <= 1'b0;
            sci     <= 1'b0;
            evt_num <= '0;
            smi_q   <= 1'b0;
        end else begin
            if (host_wr) begin
                ibf     <= 1'b1;
                in_byte <= host_wdata;
                in_cmd  <= host_cmd_port;
            end else if (consume) begin
                ibf <= 1'b0;
            end
            if (obf_set) begin
                obf   <= 1'b1;
                out_q <= out_byte;
                qry_q <= out_is_query;
            end else if (host_rd_data) begin
                obf <= 1'b0;
            end
            if (burst_on)       burst <= 1'b1;
            else if (burst_off) burst <= 1'b0;
            if (evt_strb) begin
                sci     <= 1'b1;
                evt_num <= evt_code;
            end else if (host_rd_data && obf && qry_q) begin
                sci <= 1'b0;
            end
            smi_q <= smi_req;
        end
    end

    assign status = {1'b0, smi_q, sci, burst, in_cmd, 1'b0, ibf, obf};
endmodule

// File: rtl/ec_host_port.sv
module ec_host_port #(
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter logic [DW-1:0] BURST_ACK = 8'h90
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic          host_cmd_port,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          evt_strb,
    input  logic [DW-1:0] evt_code,
    input  logic          smi_req
);
    logic          wr_acc, rd_data_acc;
    logic          ibf_w, obf_w, in_cmd_w, burst_w, sci_w;
    logic [DW-1:0] in_byte_w, out_w, evt_num_w, rd_byte_w, ob_byte_w, mem_wdata_w;
    logic [7:0]    status_w;
    logic          consume_w, busy_w, obf_set_w, is_qry_w, bon_w, boff_w;
    logic          mem_we_w, mem_re_w;
    logic [AW-1:0] mem_addr_w;

    assign wr_acc      = host_sel && host_wr;
    assign rd_data_acc = host_sel && !host_wr && !host_cmd_port;

    ec_status #(.DW(DW)) u_status (
        .clk(clk), .rst_n(rst_n),
        .host_wr(wr_acc), .host_rd_data(rd_data_acc),
        .host_cmd_port(host_cmd_port), .host_wdata(host_wdata),
        .consume(consume_w), .obf_set(obf_set_w), .out_byte(ob_byte_w),
        .out_is_query(is_qry_w), .burst_on(bon_w), .burst_off(boff_w),
        .evt_strb(evt_strb), .evt_code(evt_code), .smi_req(smi_req),
        .ibf(ibf_w), .obf(obf_w), .in_cmd(in_cmd_w), .in_byte(in_byte_w),
        .out_q(out_w), .burst(burst_w), .sci(sci_w), .evt_num(evt_num_w),
        .status(status_w)
    );

    ec_seq #(.AW(AW), .DW(DW), .BURST_ACK(BURST_ACK)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ibf(ibf_w), .in_cmd(in_cmd_w), .in_byte(in_byte_w),
        .rd_byte(rd_byte_w), .sci_pend(sci_w), .evt_num(evt_num_w),
        .consume(consume_w), .busy(busy_w), .obf_set(obf_set_w),
        .out_byte(ob_byte_w), .out_is_query(is_qry_w),
        .burst_on(bon_w), .burst_off(boff_w),
        .mem_we(mem_we_w), .mem_re(mem_re_w), .mem_addr(mem_addr_w),
        .mem_wdata(mem_wdata_w)
    );

    ec_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .we(mem_we_w), .waddr(mem_addr_w), .wdata(mem_wdata_w),
        .re(mem_re_w), .raddr(mem_addr_w), .rdata(rd_byte_w)
    );

    assign host_rdata = host_cmd_port ? status_w : out_w;
endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_acc,
    input logic          rd_data_acc,
    input logic          ibf,
    input logic          obf,
    input logic          busy,
    input logic          obf_set,
    input logic          burst,
    input logic [DW-1:0] out_q,
    input logic          evt_strb,
    input logic          sci
);
    assert_ibf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> ibf);

    assert_ibf_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && !busy && !wr_acc) |=> !ibf);

    assert_fetch_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_burst_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst) |-> (obf && out_q == 8'h90));

    assert_evt_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strb |=> sci);

    assert_obf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_acc && !obf_set) |=> !obf);
endmodule

bind ec_host_port ec_host_port_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_data_acc(rd_data_acc),
    .ibf(ibf_w), .obf(obf_w), .busy(busy_w), .obf_set(obf_set_w),
    .burst(burst_w), .out_q(out_w), .evt_strb(evt_strb), .sci(sci_w)
);

// File: tb/tb_ec_host_port.sv
module tb_ec_host_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_wr = 1'b0, host_cmd_port = 1'b1;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       evt_strb = 1'b0;
    logic [7:0] evt_code = 8'h00;
    logic       smi_req = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] model [256];
    bit         known [256];

    ec_host_port dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_cmd_port(host_cmd_port), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .evt_strb(evt_strb), .evt_code(evt_code),
        .smi_req(smi_req)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Called at a negedge; reads the status byte without side effects.
    task automatic peek_status(output logic [7:0] s);
        host_cmd_port = 1'b1;
        #1 s = host_rdata;
    endtask

    task automatic wait_flag(input int bitpos, input logic want, input string req);
        logic [7:0] s;
        for (int n = 0; n < 50; n++) begin
            peek_status(s);
            if (s[bitpos] == want) return;
            @(negedge clk);
        end
        check(req, s, {8{want}} & (8'h1 << bitpos));
    endtask

    // Single write access, no pacing; returns at the negedge after the edge.
    task automatic raw_write(input logic to_cmd, input logic [7:0] b);
        host_sel = 1'b1; host_wr = 1'b1; host_cmd_port = to_cmd; host_wdata = b;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_write(input logic to_cmd, input logic [7:0] b);
        wait_flag(1, 1'b0, "ibf_wait");
        raw_write(to_cmd, b);
    endtask

    task automatic host_read(output logic [7:0] b, input string req);
        wait_flag(0, 1'b1, req);
        host_sel = 1'b1; host_wr = 1'b0; host_cmd_port = 1'b0;
        #1 b = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        host_write(1'b1, 8'h81);
        host_write(1'b0, a);
        host_write(1'b0, d);
        model[a] = d;
        known[a] = 1'b1;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        host_write(1'b1, 8'h80);
        host_write(1'b0, a);
        host_read(d, "R3_fetch");
    endtask

    initial begin
        logic [7:0] s, d;
        void'($urandom(32'd7211));
        for (int i = 0; i < 256; i++) known[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        peek_status(s); check("R1_reset_status", s, 8'h00);

        // R2: command byte flag and IBF timing
        raw_write(1'b1, 8'h83);
        peek_status(s); check("R2_ibf_cmd", s, 8'h0A);
        @(negedge clk);
        peek_status(s); check("R2_ibf_clear", s, 8'h08);
        // R2/R9: stray data byte while idle
        raw_write(1'b0, 8'h55);
        peek_status(s); check("R2_ibf_data", s, 8'h02);
        @(negedge clk);
        peek_status(s); check("R9_idle_data_ignored", s, 8'h00);

        // R4 then R3 with flag timing
        reg_write(8'h10, 8'hA5);
        host_write(1'b1, 8'h80);
        wait_flag(1, 1'b0, "ibf_wait");
        raw_write(1'b0, 8'h10);
        peek_status(s); check("R3_obf_t0", {7'b0, s[0]}, 8'h00);
        @(negedge clk);
        peek_status(s); check("R3_obf_t1", {7'b0, s[0]}, 8'h00);
        @(negedge clk);
        peek_status(s); check("R3_obf_t2", {7'b0, s[0]}, 8'h01);
        host_read(d, "R3_read");
        check("R3_R4_data", d, 8'hA5);
        peek_status(s); check("R8_obf_cleared", {7'b0, s[0]}, 8'h00);

        // R5 burst enable
        host_write(1'b1, 8'h82);
        wait_flag(0, 1'b1, "R5_obf");
        peek_status(s); check("R5_burst_bit", {3'b0, s[4], 4'b0}, 8'h10);
        host_read(d, "R5_read");
        check("R5_ack", d, 8'h90);
        peek_status(s); check("R8_obf_after_ack", {7'b0, s[0]}, 8'h00);

        // R6 burst disable
        host_write(1'b1, 8'h83);
        repeat (3) @(negedge clk);
        peek_status(s); check("R6_burst_off", s & 8'h11, 8'h00);

        // R7 query without and with a pending event
        host_write(1'b1, 8'h84);
        host_read(d, "R7_q0");
        check("R7_query_none", d, 8'h00);
        evt_strb = 1'b1; evt_code = 8'h3C;
        @(negedge clk);
        evt_strb = 1'b0;
        peek_status(s); check("R7_sci_set", s & 8'h20, 8'h20);
        host_write(1'b1, 8'h84);
        host_read(d, "R7_q1");
        check("R7_query_code", d, 8'h3C);
        peek_status(s); check("R7_sci_cleared", s & 8'h20, 8'h00);

        // R9 unknown command and stray data
        host_write(1'b1, 8'h99);
        host_write(1'b0, 8'h10);
        host_write(1'b0, 8'h77);
        repeat (2) @(negedge clk);
        peek_status(s); check("R9_no_obf", s & 8'h01, 8'h00);
        reg_read(8'h10, d);
        check("R9_reg_unchanged", d, 8'hA5);

        // R10 abort a write after its address byte
        reg_write(8'h20, 8'h11);
        host_write(1'b1, 8'h81);
        host_write(1'b0, 8'h20);
        host_write(1'b1, 8'h80);
        host_write(1'b0, 8'h20);
        host_read(d, "R10_read");
        check("R10_abort_read", d, 8'h11);
        reg_read(8'h20, d);
        check("R10_not_stored", d, 8'h11);

        // R11 SMI mirror
        smi_req = 1'b1;
        @(negedge clk);
        peek_status(s); check("R11_smi", s & 8'h40, 8'h40);
        smi_req = 1'b0;

        // Random register traffic against the bench model (R3, R4)
        for (int i = 0; i < 40; i++) begin
            logic [7:0] a, v;
            a = 8'($urandom());
            v = 8'($urandom());
            reg_write(a, v);
        end
        for (int i = 0; i < 256; i++) begin
            if (known[i]) begin
                reg_read(8'(i), d);
                check("R3_R4_random", d, model[i]);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule